// File: doc/BRIEF.md
# Privilege-Segmented Address Decoder with Fault Capture

This block sits between the load/store address path and the TLB of a 32-bit core. Each access presents a virtual address, its direction, the current privilege mode and the error-level status bit. The block decides which privilege segment the address falls in. It checks that the current mode may use that segment. It then either produces the physical address directly, for the unmapped windows, or passes through the translation the TLB returned, for the mapped windows.

When an access fails, the block reports an exception cause code and a refill flag. The failure can be a segment the mode may not touch, or a TLB miss, invalid entry or write to a clean page. On the next clock edge it records the faulting address. The context and entry-high views are built from that record, so the refill handler can find the page-table slot and the page pair to load. The page-table base for the context view and the address-space ID for the entry-high view come from the registers that own them elsewhere in the core.

Top module: `seg_xlate_top`

## Requirements
- R1: With `erl_i` high, any address below 0x8000_0000 maps one-to-one (`paddr_o` = `vaddr_i`) in every mode, with no fault, whatever `tlb_res_i` says.
- R2: With `erl_i` low, an address below 0x8000_0000 is mapped in every mode. `tlb_res_i` is encoded 0 hit, 1 miss, 2 invalid, 3 dirty. On a hit `paddr_o` = `tlb_paddr_i` with no fault.
- R3: Addresses 0x8000_0000 to 0x9FFF_FFFF in kernel mode (`mode_i` 2 or 3) give `paddr_o` = address − 0x8000_0000, ignoring `tlb_res_i`.
- R4: Addresses 0xA000_0000 to 0xBFFF_FFFF in kernel mode give `paddr_o` = address − 0xA000_0000, ignoring `tlb_res_i`.
- R5: Addresses 0xC000_0000 to 0xDFFF_FFFF are mapped through the TLB in supervisor (`mode_i` 1) or kernel mode, and are an address error in user mode (`mode_i` 0).
- R6: Addresses at or above 0xE000_0000 are mapped through the TLB in kernel mode only, and are an address error in user and supervisor mode.
- R7: The two unmapped windows (0x8000_0000 to 0xBFFF_FFFF) are an address error in user and supervisor mode.
- R8: An address error sets `fault_o` with `exc_code_o` 4 on a read and 5 on a write, and `refill_o` low. A fault forces `paddr_o` to zero. With no fault `exc_code_o` is 0.
- R9: A TLB miss on an allowed mapped access gives code 2 on a read and 3 on a write, with `refill_o` high. An invalid entry gives the same codes with `refill_o` low. Dirty gives code 1.
- R10: On a clock edge where `req_i` and `fault_o` are both high, `badvaddr_o` takes `vaddr_i` from the next cycle on. Reset clears it to zero.
- R11: `context_o` is {`ctx_base_i`[8:0], captured address bits [31:13], 4'b0}. That places (address >> 9) & 0x7F_FFF0 in bits [22:4].
- R12: `entryhi_o` is {captured address bits [31:13], 5'b0, `asid_i`[7:0]}, so a fault leaves the 8-bit address-space ID untouched.
- R13: The captured address holds its value on every edge without `req_i` and `fault_o` both high. This includes a faulting address presented with `req_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access valid this cycle |
| vaddr_i | input | 32 | Virtual address |
| write_i | input | 1 | 1 = store, 0 = load |
| mode_i | input | 2 | 0 user, 1 supervisor, 2/3 kernel |
| erl_i | input | 1 | Error-level status bit |
| tlb_res_i | input | 2 | TLB lookup result: 0 hit, 1 miss, 2 invalid, 3 dirty |
| tlb_paddr_i | input | 32 | Physical address from the TLB |
| asid_i | input | 8 | Current address-space ID |
| ctx_base_i | input | 9 | Page-table base field of the context view |
| paddr_o | output | 32 | Physical address, zero on a fault |
| mapped_o | output | 1 | Access uses the TLB result |
| fault_o | output | 1 | Access faults |
| exc_code_o | output | 5 | Exception cause code, 0 if none |
| refill_o | output | 1 | Fault is a TLB refill miss |
| badvaddr_o | output | 32 | Captured faulting address |
| context_o | output | 32 | Context view of the capture |
| entryhi_o | output | 32 | Entry-high view of the capture |

## Verification
Two functions can meet in one cycle: the segment permission check and the TLB fault classification. A mapped access that is both out of privilege and reported by the TLB as a miss, invalid or dirty must come out as an address error. The bench provokes this with random user and supervisor accesses to the top two windows under every TLB result, and compares the code against a bench model in which privilege is checked first. Fault capture is judged on the following cycle, including vectors whose address would fault but whose request is low.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int unsigned AW       = 32;
  localparam int unsigned ASID_W   = 8;
  localparam int unsigned VPN2_LSB = 13;
  localparam int unsigned VPN2_W   = AW - VPN2_LSB;
  localparam int unsigned CTX_LSB  = 4;
  localparam int unsigned CTX_BW   = AW - CTX_LSB - VPN2_W;
  localparam int unsigned EXC_W    = 5;

  typedef enum logic [1:0] {
    MODE_USER = 2'd0,
    MODE_SUP  = 2'd1,
    MODE_KERN = 2'd2,
    MODE_KRN2 = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    TLB_HIT   = 2'd0,
    TLB_MISS  = 2'd1,
    TLB_INVAL = 2'd2,
    TLB_DIRTY = 2'd3
  } tlb_res_e;

  typedef enum logic [2:0] {
    SEG_USER, SEG_KUNC0, SEG_KUNC1, SEG_SUPM, SEG_KERNM
  } seg_e;

  localparam logic [EXC_W-1:0] EXC_NONE = 5'd0;
  localparam logic [EXC_W-1:0] EXC_MOD  = 5'd1;
  localparam logic [EXC_W-1:0] EXC_TLBL = 5'd2;
  localparam logic [EXC_W-1:0] EXC_TLBS = 5'd3;
  localparam logic [EXC_W-1:0] EXC_ADEL = 5'd4;
  localparam logic [EXC_W-1:0] EXC_ADES = 5'd5;
endpackage

// File: rtl/seg_decode.sv
module seg_decode
  import seg_xlate_pkg::*;
(
  input  logic [AW-1:0] vaddr_i,
  input  logic [1:0]    mode_i,
  input  logic          erl_i,
  output logic          allowed_o,
  output logic          mapped_o,
  output logic [AW-1:0] direct_pa_o
);
  seg_e seg;
  logic is_kern, is_sup;

  assign is_kern = mode_i[1];
  assign is_sup  = (mode_i == MODE_SUP);

  always_comb begin
    if (!vaddr_i[AW-1]) seg = SEG_USER;
    else begin
      unique case (vaddr_i[AW-2:AW-3])
        2'b00:   seg = SEG_KUNC0;
        2'b01:   seg = SEG_KUNC1;
        2'b10:   seg = SEG_SUPM;
        default: seg = SEG_KERNM;
      endcase
    end
  end

  always_comb begin
    allowed_o   = 1'b0;
    mapped_o    = 1'b0;
    direct_pa_o = '0;
    unique case (seg)
      SEG_USER: begin
        allowed_o = 1'b1;
        mapped_o  = !erl_i;
        if (erl_i) direct_pa_o = vaddr_i;
      end
      SEG_KUNC0, SEG_KUNC1: begin
        allowed_o   = is_kern;
        direct_pa_o = {3'b000, vaddr_i[AW-4:0]};
      end
      SEG_SUPM: begin
        allowed_o = is_kern || is_sup;
        mapped_o  = 1'b1;
      end
      default: begin
        allowed_o = is_kern;
        mapped_o  = 1'b1;
      end
    endcase
  end

  // R7
  unc_user_chk: assert final (!(vaddr_i[AW-1:AW-2] == 2'b10 && !mode_i[1]) || !allowed_o);
  // R3
  unc_top_chk: assert final (mapped_o || direct_pa_o[AW-1:AW-3] == 3'b000 || !vaddr_i[AW-1]);
endmodule

// File: rtl/fault_class.sv
module fault_class
  import seg_xlate_pkg::*;
(
  input  logic             allowed_i,
  input  logic             mapped_i,
  input  logic             write_i,
  input  logic [1:0]       tlb_res_i,
  output logic             fault_o,
  output logic [EXC_W-1:0] exc_code_o,
  output logic             refill_o
);
  always_comb begin
    fault_o    = 1'b0;
    exc_code_o = EXC_NONE;
    refill_o   = 1'b0;
    if (!allowed_i) begin
      // privilege beats any TLB outcome
      fault_o    = 1'b1;
      exc_code_o = write_i ? EXC_ADES : EXC_ADEL;
    end else if (mapped_i) begin
      unique case (tlb_res_e'(tlb_res_i))
        TLB_HIT: ;
        TLB_MISS: begin
          fault_o    = 1'b1;
          exc_code_o = write_i ? EXC_TLBS : EXC_TLBL;
          refill_o   = 1'b1;
        end
        TLB_INVAL: begin
          fault_o    = 1'b1;
          exc_code_o = write_i ? EXC_TLBS : EXC_TLBL;
        end
        default: begin
          fault_o    = 1'b1;
          exc_code_o = EXC_MOD;
        end
      endcase
    end
  end

  // R9
  refill_code_chk: assert final (!refill_o || exc_code_o == EXC_TLBL || exc_code_o == EXC_TLBS);
  // R8
  none_code_chk: assert final (fault_o == (exc_code_o != EXC_NONE));
endmodule

// File: rtl/fault_capture.sv
module fault_capture
  import seg_xlate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [AW-1:0]     vaddr_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [CTX_BW-1:0] ctx_base_i,
  output logic [AW-1:0]     badvaddr_o,
  output logic [AW-1:0]     context_o,
  output logic [AW-1:0]     entryhi_o
);
  logic [AW-1:0] bad_q;
  logic [VPN2_W-1:0] vpn2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    bad_q <= '0;
    else if (cap_i) bad_q <= vaddr_i;
  end

  assign vpn2       = bad_q[AW-1:VPN2_LSB];
  assign badvaddr_o = bad_q;
  assign context_o  = {ctx_base_i, vpn2, {CTX_LSB{1'b0}}};
  assign entryhi_o  = {vpn2, {(VPN2_LSB-ASID_W){1'b0}}, asid_i};

  // R10
  cap_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> badvaddr_o == $past(vaddr_i));
  // R13
  cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(badvaddr_o));
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import seg_xlate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [AW-1:0]     vaddr_i,
  input  logic              write_i,
  input  logic [1:0]        mode_i,
  input  logic              erl_i,
  input  logic [1:0]        tlb_res_i,
  input  logic [AW-1:0]     tlb_paddr_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [CTX_BW-1:0] ctx_base_i,
  output logic [AW-1:0]     paddr_o,
  output logic              mapped_o,
  output logic              fault_o,
  output logic [EXC_W-1:0]  exc_code_o,
  output logic              refill_o,
  output logic [AW-1:0]     badvaddr_o,
  output logic [AW-1:0]     context_o,
  output logic [AW-1:0]     entryhi_o
);
  logic          allowed, mapped;
  logic [AW-1:0] direct_pa;

  seg_decode u_seg (
    .vaddr_i     (vaddr_i),
    .mode_i      (mode_i),
    .erl_i       (erl_i),
    .allowed_o   (allowed),
    .mapped_o    (mapped),
    .direct_pa_o (direct_pa)
  );

  fault_class u_fcls (
    .allowed_i  (allowed),
    .mapped_i   (mapped),
    .write_i    (write_i),
    .tlb_res_i  (tlb_res_i),
    .fault_o    (fault_o),
    .exc_code_o (exc_code_o),
    .refill_o   (refill_o)
  );

  assign mapped_o = mapped;
  assign paddr_o  = fault_o ? '0 : (mapped ? tlb_paddr_i : direct_pa);

  fault_capture u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (req_i && fault_o),
    .vaddr_i    (vaddr_i),
    .asid_i     (asid_i),
    .ctx_base_i (ctx_base_i),
    .badvaddr_o (badvaddr_o),
    .context_o  (context_o),
    .entryhi_o  (entryhi_o)
  );

  // R6
  kseg3_user_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vaddr_i[31:29] == 3'b111 && !mode_i[1]) |-> (exc_code_o == EXC_ADEL || exc_code_o == EXC_ADES));
  // R1
  erl_ident_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erl_i && !vaddr_i[31]) |-> (!fault_o && paddr_o == vaddr_i));
  // R12
  asid_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entryhi_o[ASID_W-1:0] == asid_i);
endmodule

// File: tb/seg_xlate_top_tb.sv
module seg_xlate_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [31:0] va = '0;
  logic        wr = 1'b0;
  logic [1:0]  md = '0;
  logic        erl = 1'b0;
  logic [1:0]  tres = '0;
  logic [31:0] tpa = '0;
  logic [7:0]  asid = '0;
  logic [8:0]  cbase = '0;
  logic [31:0] paddr, bad, ctx, ehi;
  logic        mapped, fault, refill;
  logic [4:0]  exc;

  int n_chk = 0, n_bad = 0;
  logic [31:0] cap_m = '0;
  bit done = 0;

  always #2 clk = ~clk;

  seg_xlate_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .vaddr_i(va), .write_i(wr),
    .mode_i(md), .erl_i(erl), .tlb_res_i(tres), .tlb_paddr_i(tpa),
    .asid_i(asid), .ctx_base_i(cbase), .paddr_o(paddr), .mapped_o(mapped),
    .fault_o(fault), .exc_code_o(exc), .refill_o(refill),
    .badvaddr_o(bad), .context_o(ctx), .entryhi_o(ehi));

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h va=%h md=%0d erl=%0b wr=%0b tres=%0d",
               r, act, exp, va, md, erl, wr, tres);
    end
  endtask

  // expected {fault, exc, refill, paddr}
  function automatic logic [38:0] model(logic [31:0] a, logic w, logic [1:0] m,
                                        logic e, logic [1:0] t, logic [31:0] tp);
    logic ok, mp; logic [31:0] pa; logic [4:0] c; logic rf, f;
    ok = 0; mp = 0; pa = 0; c = 0; rf = 0; f = 0;
    if (a < 32'h8000_0000) begin ok = 1; mp = !e; pa = a; end
    else if (a < 32'hA000_0000) begin ok = (m >= 2); pa = a - 32'h8000_0000; end
    else if (a < 32'hC000_0000) begin ok = (m >= 2); pa = a - 32'hA000_0000; end
    else if (a < 32'hE000_0000) begin ok = (m != 0); mp = 1; end
    else begin ok = (m >= 2); mp = 1; end
    if (!ok) begin f = 1; c = w ? 5 : 4; end
    else if (mp) begin
      pa = tp;
      case (t)
        2'd1: begin f = 1; c = w ? 3 : 2; rf = 1; end
        2'd2: begin f = 1; c = w ? 3 : 2; end
        2'd3: begin f = 1; c = 1; end
        default: ;
      endcase
    end
    if (f) pa = 0;
    return {f, c, rf, pa};
  endfunction

  task automatic apply(string r, logic rq, logic [31:0] a, logic w, logic [1:0] m,
                       logic e, logic [1:0] t);
    logic [38:0] ex;
    @(negedge clk);
    req = rq; va = a; wr = w; md = m; erl = e; tres = t;
    tpa = $urandom; asid = 8'($urandom); cbase = 9'($urandom);
    #1;
    ex = model(a, w, m, e, t, tpa);
    chk({r, " fault"}, 32'(fault), 32'(ex[38]));
    chk({r, " exc R8 R9"}, 32'(exc), 32'(ex[37:33]));
    chk({r, " refill R9"}, 32'(refill), 32'(ex[32]));
    chk({r, " paddr"}, paddr, ex[31:0]);
    if (rq && ex[38]) cap_m = a;
    @(negedge clk);
    chk("R10 R13 badvaddr", bad, cap_m);
    chk("R11 context", ctx, {cbase, cap_m[31:13], 4'b0});
    chk("R12 entryhi", ehi, {cap_m[31:13], 5'b0, asid});
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    chk("reset badvaddr R10", bad, 32'h0);
    chk("reset entryhi R12", ehi, {24'h0, asid});
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // directed corners
    apply("R1 erl ident", 1, 32'h7FFF_FFFF, 1, 0, 1, 2'd1);
    apply("R2 useg hit", 1, 32'h1234_5678, 0, 0, 0, 2'd0);
    apply("R2 useg miss", 1, 32'h0000_2000, 1, 0, 0, 2'd1);
    apply("R3 kseg0 lo", 1, 32'h8000_0000, 0, 2, 0, 2'd3);
    apply("R3 kseg0 hi", 1, 32'h9FFF_FFFF, 1, 3, 0, 2'd1);
    apply("R4 kseg1", 1, 32'hA000_1004, 0, 2, 0, 2'd2);
    apply("R4 kseg1 hi", 1, 32'hBFFF_FFFC, 0, 2, 1, 2'd0);
    apply("R5 kseg2 sup", 1, 32'hC000_0000, 1, 1, 0, 2'd0);
    apply("R5 kseg2 user", 1, 32'hDFFF_E000, 0, 0, 0, 2'd1);
    apply("R6 kseg3 sup", 1, 32'hE000_0000, 1, 1, 0, 2'd3);
    apply("R6 kseg3 kern dirty", 1, 32'hFFFF_F000, 1, 2, 0, 2'd3);
    apply("R7 kseg0 sup", 1, 32'h8000_4000, 0, 1, 0, 2'd0);
    apply("R7 kseg1 user", 1, 32'hA123_4567, 1, 0, 0, 2'd0);
    apply("R9 invalid read", 1, 32'h4000_6000, 0, 2, 0, 2'd2);
    apply("R13 no req", 0, 32'hE555_5555, 0, 0, 0, 2'd1);
    apply("R13 hit no cap", 1, 32'h0040_0000, 0, 0, 0, 2'd0);
    // random, biased toward privilege/TLB overlap
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a;
      a = $urandom;
      if (i % 3 == 0) a[31:30] = 2'b11;
      apply("rand R5 R6 R8 R9", ($urandom % 5) != 0, a, 1'($urandom),
            2'($urandom), ($urandom % 4) == 0, 2'($urandom));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule